// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block produces the dynamic-drive scan timing for a dot-matrix panel of 128 segment columns by 64 common rows. As timing master it makes the line clock, the frame sync and the AC alternation signal from the system clock and drives them outward. As timing slave it takes the same three signals in from a partner device and follows them. A row counter advances once per line and is cleared at the start of each frame. A start-line offset is added to it to form the display-memory row address.

On every rising edge of the line clock the block latches one row of segment data from display memory and records which common line is to be energised. It then emits a drive-level code for every segment pin and every common pin. Straps select 1/48 or 1/64 duty, the common scan direction and the segment column order. The analog level generator turns the codes into voltages. The codes use this encoding throughout: 0 = V0, 1 = V1, 2 = V2, 3 = V3, 4 = V4, 5 = GND.

Top module: `lcd_scan_timer`

## Requirements
- R1: With `master` high, `cl_out` toggles every `CL_DIV` system clocks and `sync_oe` is high. With `master` low, `sync_oe` is low.
- R2: In master mode, `frm_out` changes only when `cl_out` falls. It is high for exactly one line period at the start of each frame, and the first falling edge after reset starts a frame. A frame lasts 64 lines with `duty64` high and 48 lines with `duty64` low.
- R3: The alternation signal `m_out` resets to 0 and inverts once per frame, on the line clock fall that raises the frame sync.
- R4: The row counter clears to 0 on a line clock fall when the frame sync is high. Otherwise it increments on each fall and wraps to 0 after the last row of the selected duty.
- R5: `row_addr` equals (row counter + start line) modulo 64. `row_page` equals `row_addr[5:3]`. The start line is written from `start_line` in any cycle with `start_we` high.
- R6: Row data on `rd_data` is latched on the line clock rising edge and held unchanged until the next rising edge.
- R7: With `com_up` high, row counter value k selects pin COMk. With `com_up` low, it selects COM(63-k).
- R8: With `seg_fwd` high, segment pin j shows latched column j. With `seg_fwd` low, it shows column 127-j.
- R9: Segment code for pin j sits at `seg_code[3j+2:3j]`. M=0 with data 0 gives V2, M=0 with data 1 gives V0, M=1 with data 0 gives V3, and M=1 with data 1 gives GND.
- R10: Common code for pin k sits at `com_code[3k+2:3k]`. M=0 gives V1 when the pin is unselected and GND when selected. M=1 gives V4 when unselected and V0 when selected. At most one pin is selected, and none is selected before the first latched line.
- R11: With `master` low, the line clock, frame sync and alternation signal are taken from `cl_in`, `frm_in` and `m_in` after a two-flop synchroniser. The row counter, latch and codes follow them.
- R12: After reset the row counter and start line are 0, all segment codes are V2 and all common codes are V1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master | input | 1 | Strap: 1 = timing master, 0 = slave |
| duty64 | input | 1 | Strap: 1 = 64-line frame, 0 = 48-line frame |
| com_up | input | 1 | Strap: common scan direction |
| seg_fwd | input | 1 | Strap: segment column order |
| start_we | input | 1 | Write strobe for the start line |
| start_line | input | 6 | New start line value |
| cl_in | input | 1 | Line clock from a master partner |
| frm_in | input | 1 | Frame sync from a master partner |
| m_in | input | 1 | Alternation signal from a master partner |
| cl_out | output | 1 | Generated line clock |
| frm_out | output | 1 | Generated frame sync |
| m_out | output | 1 | Generated alternation signal |
| sync_oe | output | 1 | Output enable for the three sync pads |
| row_addr | output | 6 | Display-memory row address |
| row_page | output | 3 | Memory page of the row address |
| rd_data | input | 128 | Row data read at `row_addr` |
| seg_code | output | 384 | Drive-level codes, 3 bits per segment pin |
| com_code | output | 192 | Drive-level codes, 3 bits per common pin |

## Verification
Memory rows carry a pattern that differs by row and is asymmetric across columns. Because of this, a wrong row offset or a reversed column order produces a visibly different code bus. Master mode runs across a frame boundary in two opposite strap settings. The first uses 64-line duty with forward directions and no offset. The second uses 48-line duty with both directions reversed and a start line of 62. This separates the wrap of the address sum from the wrap of the row counter, and both M polarities are exercised. In slave mode the sync lines are driven by hand, which isolates presetting from advancing. Changing M with no new line clock edge shows that the codes depend on M alone.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int CL_DIV = 8,
  parameter int NSEG   = 128,
  parameter int NCOM   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master,
  input  logic                 duty64,
  input  logic                 com_up,
  input  logic                 seg_fwd,
  input  logic                 start_we,
  input  logic [$clog2(NCOM)-1:0] start_line,
  input  logic                 cl_in,
  input  logic                 frm_in,
  input  logic                 m_in,
  output logic                 cl_out,
  output logic                 frm_out,
  output logic                 m_out,
  output logic                 sync_oe,
  output logic [$clog2(NCOM)-1:0] row_addr,
  output logic [2:0]           row_page,
  input  logic [NSEG-1:0]      rd_data,
  output logic [3*NSEG-1:0]    seg_code,
  output logic [3*NCOM-1:0]    com_code
);
  localparam int ZW = $clog2(NCOM);
  localparam int DW = (CL_DIV > 1) ? $clog2(CL_DIV) : 1;
  localparam logic [2:0] LV_V0 = 3'd0, LV_V1 = 3'd1, LV_V2 = 3'd2,
                         LV_V3 = 3'd3, LV_V4 = 3'd4, LV_GND = 3'd5;

  wire [ZW-1:0] last_row = duty64 ? ZW'(NCOM - 1) : ZW'(NCOM * 3 / 4 - 1);

  logic [DW-1:0] div_q;
  logic          cl_q, frm_q, m_q;
  logic [ZW-1:0] gen_row;
  wire           div_end = (div_q == DW'(CL_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; cl_q <= 1'b1; frm_q <= 1'b0; m_q <= 1'b0; gen_row <= '1;
    end else if (!master) begin
      div_q <= '0; cl_q <= 1'b1; frm_q <= 1'b0; m_q <= 1'b0; gen_row <= '1;
    end else if (div_end) begin
      div_q <= '0;
      cl_q  <= ~cl_q;
      if (cl_q) begin
        if (gen_row >= last_row) begin
          gen_row <= '0; frm_q <= 1'b1; m_q <= ~m_q;
        end else begin
          gen_row <= gen_row + 1'b1; frm_q <= 1'b0;
        end
      end
    end else
      div_q <= div_q + 1'b1;

  assign cl_out  = cl_q;
  assign frm_out = frm_q;
  assign m_out   = m_q;
  assign sync_oe = master;

  logic [2:0] sy1, sy2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin sy1 <= '0; sy2 <= '0; end
    else begin sy1 <= {m_in, frm_in, cl_in}; sy2 <= sy1; end

  wire cl_s  = master ? cl_q  : sy2[0];
  wire frm_s = master ? frm_q : sy2[1];
  wire m_s   = master ? m_q   : sy2[2];

  logic armed, cl_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin armed <= 1'b0; cl_d <= 1'b0; end
    else begin armed <= 1'b1; cl_d <= cl_s; end

  wire rise_ev = armed & cl_s & ~cl_d;
  wire fall_ev = armed & ~cl_s & cl_d;

  logic [ZW-1:0] z, start_q, com_idx;
  logic [NSEG-1:0] row_lat;
  logic live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) z <= '0;
    else if (fall_ev) z <= (frm_s || z >= last_row) ? '0 : z + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) start_q <= '0;
    else if (start_we) start_q <= start_line;

  assign row_addr = z + start_q;
  assign row_page = row_addr[ZW-1:ZW-3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin row_lat <= '0; com_idx <= '0; live <= 1'b0; end
    else if (rise_ev) begin row_lat <= rd_data; com_idx <= z; live <= 1'b1; end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    wire d = seg_fwd ? row_lat[j] : row_lat[NSEG-1-j];
    assign seg_code[3*j +: 3] = m_s ? (d ? LV_GND : LV_V3) : (d ? LV_V0 : LV_V2);
  end

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    wire sel = live && (com_up ? (com_idx == ZW'(k)) : (com_idx == ZW'(NCOM-1-k)));
    assign com_code[3*k +: 3] = m_s ? (sel ? LV_V0 : LV_V4) : (sel ? LV_GND : LV_V1);
  end
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int NSEG = 128,
  parameter int NCOM = 64,
  parameter int ZW   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master,
  input logic              cl_out,
  input logic              frm_out,
  input logic              m_out,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic              frm_s,
  input logic [ZW-1:0]     z,
  input logic [NSEG-1:0]   row_lat,
  input logic [3*NCOM-1:0] com_code
);
  logic [NCOM-1:0] sel_v;
  always_comb
    for (int k = 0; k < NCOM; k++)
      sel_v[k] = (com_code[3*k +: 3] == 3'd5) || (com_code[3*k +: 3] == 3'd0);

  assert_frm_on_cl_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master && !$stable(frm_out) |-> !$stable(cl_out) && !cl_out);

  assert_m_with_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    master && !$stable(m_out) |-> $rose(frm_out));

  assert_z_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev && frm_s |=> z == '0);

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev |=> $stable(row_lat));

  assert_one_common_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_v));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.NSEG(NSEG), .NCOM(NCOM), .ZW(ZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .cl_out(cl_out), .frm_out(frm_out),
  .m_out(m_out), .rise_ev(rise_ev), .fall_ev(fall_ev), .frm_s(frm_s), .z(z),
  .row_lat(row_lat), .com_code(com_code)
);

// File: tb/sim_lcd_scan_timer.sv
`timescale 1ns/1ps
module sim_lcd_scan_timer;
  localparam int CLD = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, duty64 = 1'b1, com_up = 1'b1, seg_fwd = 1'b1;
  logic start_we = 1'b0;
  logic [5:0] start_line = '0;
  logic cl_in = 1'b0, frm_in = 1'b0, m_in = 1'b0;
  logic cl_out, frm_out, m_out, sync_oe;
  logic [5:0] row_addr;
  logic [2:0] row_page;
  logic [127:0] rd_data;
  logic [383:0] seg_code;
  logic [191:0] com_code;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [127:0] rowpat(input logic [5:0] r);
    logic [127:0] v;
    for (int c = 0; c < 128; c++)
      v[c] = ((((c * 7) + (int'(r) * 13)) % 5) == 0) ^ (c < int'(r)) ^ (c >= 120);
    return v;
  endfunction

  assign rd_data = rowpat(row_addr);

  lcd_scan_timer #(.CL_DIV(CLD)) u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .duty64(duty64), .com_up(com_up),
    .seg_fwd(seg_fwd), .start_we(start_we), .start_line(start_line),
    .cl_in(cl_in), .frm_in(frm_in), .m_in(m_in), .cl_out(cl_out), .frm_out(frm_out),
    .m_out(m_out), .sync_oe(sync_oe), .row_addr(row_addr), .row_page(row_page),
    .rd_data(rd_data), .seg_code(seg_code), .com_code(com_code));

  function automatic logic [383:0] exp_seg(input logic [127:0] r, input logic m, input logic fwd);
    logic [383:0] v;
    for (int j = 0; j < 128; j++) begin
      logic d;
      d = fwd ? r[j] : r[127-j];
      v[3*j +: 3] = m ? (d ? 3'd5 : 3'd3) : (d ? 3'd0 : 3'd2);
    end
    return v;
  endfunction

  function automatic logic [191:0] exp_com(input int zi, input logic m, input logic up, input logic lv);
    logic [191:0] v;
    for (int k = 0; k < 64; k++) begin
      logic s;
      s = lv && (up ? (zi == k) : (zi == 63 - k));
      v[3*k +: 3] = m ? (s ? 3'd0 : 3'd4) : (s ? 3'd5 : 3'd1);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [383:0] act, input logic [383:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic ms, input logic ds, input logic up, input logic fwd);
    rst_n = 1'b0; master = ms; duty64 = ds; com_up = up; seg_fwd = fwd;
    cl_in = 1'b0; frm_in = 1'b0; m_in = 1'b0; start_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_start(input logic [5:0] v);
    start_line = v; start_we = 1'b1;
    @(negedge clk);
    start_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1, 1'b1, 1'b1);
    chk(row_addr == 6'd0, "R12", "row_addr", 384'(row_addr), 384'(0));
    chk(seg_code == exp_seg('0, 1'b0, 1'b1), "R12", "seg codes", seg_code, exp_seg('0, 1'b0, 1'b1));
    chk(com_code == exp_com(0, 1'b0, 1'b1, 1'b0), "R12", "com codes", 384'(com_code), 384'(exp_com(0, 1'b0, 1'b1, 1'b0)));
    chk(sync_oe == 1'b1, "R1", "master oe", 384'(sync_oe), 384'(1));
    chk(m_out == 1'b0, "R3", "m after reset", 384'(m_out), 384'(0));
  endtask

  task automatic t_master(input logic ds, input logic up, input logic fwd,
                          input logic [5:0] st, input int nlines);
    int rows, ez, lines, last_rise, since, nfrm;
    logic em, pc, first;
    do_reset(1'b1, ds, up, fwd);
    set_start(st);
    rows = ds ? 64 : 48;
    ez = 0; em = 1'b0; lines = 0; last_rise = -1; since = 0; nfrm = 0; first = 1'b1;
    pc = cl_out;
    while (lines < nlines) begin
      @(negedge clk);
      if (pc && !cl_out) begin
        logic efrm;
        efrm = first || (ez == rows - 1);
        chk(frm_out == efrm, "R2", "frame sync at fall", 384'(frm_out), 384'(efrm));
        since++;
        if (efrm) begin
          if (!first) chk(since == rows, "R2", "frame length", 384'(since), 384'(rows));
          since = 0; ez = 0; em = ~em; nfrm++;
        end else
          ez = (ez == rows - 1) ? 0 : ez + 1;
        first = 1'b0;
      end
      if (!pc && cl_out) begin
        logic [5:0] ea;
        if (last_rise >= 0)
          chk(cyc - last_rise == 2 * CLD, "R1", "line period", 384'(cyc - last_rise), 384'(2 * CLD));
        last_rise = cyc;
        @(negedge clk); @(negedge clk);
        ea = 6'(ez + int'(st));
        chk(row_addr == ea, "R5", "row address", 384'(row_addr), 384'(ea));
        chk(row_page == ea[5:3], "R5", "row page", 384'(row_page), 384'(ea[5:3]));
        chk(m_out == em, "R3", "alternation", 384'(m_out), 384'(em));
        chk(seg_code == exp_seg(rowpat(ea), em, fwd), "R6 R8 R9", "segment codes",
            seg_code, exp_seg(rowpat(ea), em, fwd));
        chk(com_code == exp_com(ez, em, up, 1'b1), "R4 R7 R10", "common codes",
            384'(com_code), 384'(exp_com(ez, em, up, 1'b1)));
        lines++;
      end
      pc = cl_out;
    end
    chk(nfrm == 2, "R2", "frames seen", 384'(nfrm), 384'(2));
  endtask

  task automatic slave_edge(input logic cl, input logic frm);
    cl_in = cl; frm_in = frm;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_slave();
    do_reset(1'b0, 1'b1, 1'b1, 1'b0);
    set_start(6'd5);
    chk(sync_oe == 1'b0, "R1", "slave oe", 384'(sync_oe), 384'(0));
    slave_edge(1'b1, 1'b0);
    chk(com_code == exp_com(0, 1'b0, 1'b1, 1'b1), "R11", "first rise latched",
        384'(com_code), 384'(exp_com(0, 1'b0, 1'b1, 1'b1)));
    slave_edge(1'b0, 1'b0);
    chk(row_addr == 6'd6, "R11 R4", "advance on fall", 384'(row_addr), 384'(6));
    slave_edge(1'b1, 1'b0);
    slave_edge(1'b0, 1'b1);
    chk(row_addr == 6'd5, "R11 R4", "preset by frame sync", 384'(row_addr), 384'(5));
    slave_edge(1'b1, 1'b1);
    chk(seg_code == exp_seg(rowpat(6'd5), 1'b0, 1'b0), "R11 R8", "slave segment",
        seg_code, exp_seg(rowpat(6'd5), 1'b0, 1'b0));
    slave_edge(1'b0, 1'b0);
    slave_edge(1'b1, 1'b0);
    chk(com_code == exp_com(1, 1'b0, 1'b1, 1'b1), "R11 R7", "slave row one",
        384'(com_code), 384'(exp_com(1, 1'b0, 1'b1, 1'b1)));
    m_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(seg_code == exp_seg(rowpat(6'd6), 1'b1, 1'b0), "R11 R9", "M=1 segment",
        seg_code, exp_seg(rowpat(6'd6), 1'b1, 1'b0));
    chk(com_code == exp_com(1, 1'b1, 1'b1, 1'b1), "R11 R10", "M=1 common",
        384'(com_code), 384'(exp_com(1, 1'b1, 1'b1, 1'b1)));
  endtask

  initial begin
    t_reset();
    t_master(1'b1, 1'b1, 1'b1, 6'd0, 70);
    t_master(1'b0, 1'b0, 1'b0, 6'd62, 52);
    t_slave();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule